// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is one counting semaphore. It holds a 16-bit count behind a single memory-mapped request port. Each request carries a write flag, a two-bit view code that selects how the access is read, a requester ID and a data word. A read through a semaphore view takes one unit: it returns the count and lowers it. A write through a semaphore view gives one unit back. The data word of that write plays no part.

Two views act on the count as a semaphore. In the waiting view, a take that finds the count at zero does not complete. The block answers with a stall and records the requester in an eight-bit parked mask. In the polling view, the same take simply returns zero. Any write that changes the count sends a one-cycle wake pulse to every parked requester and empties the mask. A woken requester is expected to repeat its access. Who wins the next take is not decided here. A raw view reads the count without side effects. A control view reports status and can load the count directly.

Every accepted request gets a registered response exactly one cycle later. The view codes are 2'b00 raw, 2'b01 control, 2'b10 waiting and 2'b11 polling.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the parked mask is empty, and rsp_valid, rsp_stall and wake are all low.
- R2: A read in view 2'b10 or 2'b11 with a nonzero count returns the count as it was before the access and lowers the count by one.
- R3: A read in view 2'b11 with the count at zero returns 0 with rsp_stall low, and the count stays 0.
- R4: A read in view 2'b10 with the count at zero returns 0 with rsp_stall high, and sets bit req_id of the parked mask.
- R5: A write in view 2'b10 or 2'b11 raises the count by exactly one, whatever the data word holds.
- R6: The count never goes past 0xFFFF. A semaphore-view write at 0xFFFF leaves the count at 0xFFFF.
- R7: A count-changing write (semaphore view, or control view) drives wake, in its response cycle, to the parked mask as it stood before that write, and leaves the mask empty.
- R8: A read in view 2'b00 returns the count and leaves it unchanged. A write in view 2'b00 changes neither the count nor the mask and raises no wake.
- R9: A read in view 2'b01 returns a status word: bit 0 is set when the count is zero, bit 1 is set when the count is 0xFFFF, bits 15:8 hold the parked mask, and all other bits are 0. A write in view 2'b01 loads the count from the low 16 data bits.
- R10: rsp_valid is high exactly in the cycle after each accepted request. A write's response carries rsp_rdata 0 and rsp_stall low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_view | input | 2 | View code |
| req_id | input | 3 | Requester ID |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_stall | output | 1 | The waiting take did not complete |
| rsp_rdata | output | 32 | Read result |
| wake | output | 8 | One-cycle wake pulse per requester |

## Verification
The assertions take for granted that at most one request arrives per cycle and that its view, write flag and ID carry known values whenever req_valid is high. They also assume that no other path alters the count between two requests. The stimulus drives each request for exactly one cycle, with fully defined fields and IDs taken from the eight legal values. It holds req_valid low through reset. Random control-view loads are kept small so that zero-count takes and parking come up often, while directed loads near 0xFFFF exercise saturation.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    VIEW_RAW  = 2'b00,
    VIEW_CTRL = 2'b01,
    VIEW_WAIT = 2'b10,
    VIEW_POLL = 2'b11
  } view_e;

  typedef enum logic [1:0] {
    RD_NONE   = 2'b00,
    RD_COUNT  = 2'b01,
    RD_STATUS = 2'b10
  } rdsel_e;

  typedef struct packed {
    logic   inc;
    logic   dec;
    logic   load;
    logic   park;
    logic   wake_all;
    logic   stall;
    rdsel_e rdsel;
  } action_t;

endpackage

// File: rtl/sem_decode.sv
module sem_decode
  import sem_pkg::*;
(
  input  logic       valid,
  input  logic       write,
  input  logic [1:0] view,
  input  logic       cnt_zero,
  output action_t    act
);

  view_e view_q;
  assign view_q = view_e'(view);

  always_comb begin
    act = '0;
    if (valid) begin
      case (view_q)
        VIEW_RAW: begin
          if (!write) act.rdsel = RD_COUNT;
        end
        VIEW_CTRL: begin
          if (write) begin
            act.load     = 1'b1;
            act.wake_all = 1'b1;
          end else begin
            act.rdsel = RD_STATUS;
          end
        end
        default: begin
          if (write) begin
            act.inc      = 1'b1;
            act.wake_all = 1'b1;
          end else begin
            act.rdsel = RD_COUNT;
            if (!cnt_zero) begin
              act.dec = 1'b1;
            end else if (view_q == VIEW_WAIT) begin
              act.park  = 1'b1;
              act.stall = 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sem_count.sv
module sem_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             is_zero,
  output logic             is_full
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_up(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] floor_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  logic [CNT_W-1:0] count_nx;

  always_comb begin
    count_nx = count;
    if (load)     count_nx = load_val;
    else if (inc) count_nx = sat_up(count);
    else if (dec) count_nx = floor_down(count);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nx;
  end

  assign is_zero = (count == '0);
  assign is_full = (count == CNT_MAX);

  assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && count == CNT_MAX) |=> (count == CNT_MAX));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !inc && count != '0) |=> ({1'b0, count} + 1'b1 == {1'b0, $past(count)}));

  assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && count != CNT_MAX) |=> ({1'b0, count} == {1'b0, $past(count)} + 1'b1));

endmodule

// File: rtl/sem_waitmask.sv
module sem_waitmask #(
  parameter int NUM_REQ = 8,
  parameter int ID_W    = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               park,
  input  logic [ID_W-1:0]    park_id,
  input  logic               wake_all,
  output logic [NUM_REQ-1:0] mask,
  output logic [NUM_REQ-1:0] wake
);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
    logic hit;
    assign hit = park && (park_id == ID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[g] <= 1'b0;
        wake[g] <= 1'b0;
      end else begin
        wake[g] <= wake_all & mask[g];
        if (wake_all)  mask[g] <= 1'b0;
        else if (hit)  mask[g] <= 1'b1;
      end
    end
  end

  assert_wake_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake & ~$past(mask)) == '0);

  assert_mask_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_all |=> (mask == '0));

  assert_park_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (park && !wake_all) |=> mask[$past(park_id)]);

endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_REQ = 8,
  parameter int ID_W    = $clog2(NUM_REQ),
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_view,
  input  logic [ID_W-1:0]    req_id,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic               rsp_stall,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [NUM_REQ-1:0] wake
);

  localparam int MASK_LSB = 8;

  action_t            act;
  logic [CNT_W-1:0]   count;
  logic               cnt_zero;
  logic               cnt_full;
  logic [NUM_REQ-1:0] parked;
  logic [DATA_W-1:0]  rd_word;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^req_wdata[DATA_W-1:CNT_W];

  function automatic logic [DATA_W-1:0] status_word(input logic z, input logic f,
                                                    input logic [NUM_REQ-1:0] m);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = z;
    w[1] = f;
    w[MASK_LSB +: NUM_REQ] = m;
    return w;
  endfunction

  sem_decode u_dec (
    .valid    (req_valid),
    .write    (req_write),
    .view     (req_view),
    .cnt_zero (cnt_zero),
    .act      (act)
  );

  sem_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (act.inc),
    .dec      (act.dec),
    .load     (act.load),
    .load_val (req_wdata[CNT_W-1:0]),
    .count    (count),
    .is_zero  (cnt_zero),
    .is_full  (cnt_full)
  );

  sem_waitmask #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_wm (
    .clk      (clk),
    .rst_n    (rst_n),
    .park     (act.park),
    .park_id  (req_id),
    .wake_all (act.wake_all),
    .mask     (parked),
    .wake     (wake)
  );

  always_comb begin
    case (act.rdsel)
      RD_COUNT:  rd_word = DATA_W'(count);
      RD_STATUS: rd_word = status_word(cnt_zero, cnt_full, parked);
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_stall <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_stall <= act.stall;
      rsp_rdata <= rd_word;
    end
  end

  assert_rsp_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  assert_stall_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> (rsp_rdata == '0 && $past(cnt_zero) && $past(req_view) == 2'b10));

  assert_bypass_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_view == 2'b00) |=> ($stable(count) && wake == '0));

  assert_poll_nostall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_view == 2'b11) |=> !rsp_stall);

endmodule

// File: tb/tb_sem_cell.sv
module tb_sem_cell;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_view = 2'b00;
  logic [2:0]  req_id = 3'd0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_stall;
  logic [31:0] rsp_rdata;
  logic [7:0]  wake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int       m_cnt  = 0;
  bit [7:0] m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_cell dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_view  (req_view),
    .req_id    (req_id),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_stall (rsp_stall),
    .rsp_rdata (rsp_rdata),
    .wake      (wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] exp_status(input int c, input bit [7:0] m);
    return {16'h0, m, 6'h0, (c == 32'hFFFF), (c == 0)};
  endfunction

  task automatic access(input bit wr, input bit [1:0] view, input bit [2:0] id,
                        input bit [31:0] data, input string req);
    bit [31:0] e_rd = '0;
    bit        e_st = 1'b0;
    bit [7:0]  e_wk = '0;
    if (view == 2'b00) begin
      if (!wr) e_rd = m_cnt;
    end else if (view == 2'b01) begin
      if (wr) begin
        e_wk = m_mask; m_mask = '0; m_cnt = data[15:0];
      end else begin
        e_rd = exp_status(m_cnt, m_mask);
      end
    end else begin
      if (wr) begin
        e_wk = m_mask; m_mask = '0;
        if (m_cnt < 32'hFFFF) m_cnt++;
      end else begin
        e_rd = m_cnt;
        if (m_cnt > 0) m_cnt--;
        else if (view == 2'b10) begin
          e_st = 1'b1; m_mask[id] = 1'b1;
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_view = view; req_id = id; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R10 valid"}, {31'h0, rsp_valid}, 32'h1);
    check({req, " rdata"}, rsp_rdata, e_rd);
    check({req, " stall"}, {31'h0, rsp_stall}, {31'h0, e_st});
    check({req, " wake"}, {24'h0, wake}, {24'h0, e_wk});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R1 wake", {24'h0, wake}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle rsp_valid", {31'h0, rsp_valid}, 32'h0);
    access(0, 2'b01, 0, 0, "R1 R9 status after reset");
    access(0, 2'b00, 0, 0, "R1 R8 raw read zero");

    // R3: polling take at zero
    access(0, 2'b11, 1, 0, "R3 poll at zero");
    access(0, 2'b01, 0, 0, "R3 mask untouched");

    // R5 with odd data, R2 takes
    access(1, 2'b10, 0, 32'hDEADBEEF, "R5 inc data ignored");
    access(1, 2'b11, 3, 32'h0, "R5 inc zero data");
    access(0, 2'b00, 0, 0, "R8 raw read two");
    access(0, 2'b10, 4, 0, "R2 wait take");
    access(0, 2'b11, 4, 0, "R2 poll take");

    // R4 parking, R8 bypass write ignored, R7 wake and retry
    access(0, 2'b10, 2, 0, "R4 park id2");
    access(0, 2'b10, 5, 0, "R4 park id5");
    access(1, 2'b00, 6, 32'h1234, "R8 raw write ignored");
    access(0, 2'b01, 0, 0, "R9 R4 status with mask");
    access(1, 2'b11, 7, 32'hFFFFFFFF, "R7 wake on inc");
    access(0, 2'b01, 0, 0, "R7 mask cleared");
    access(0, 2'b10, 2, 0, "R7 retry id2 succeeds");
    access(0, 2'b10, 5, 0, "R4 retry id5 parks again");
    access(1, 2'b01, 0, 32'hABCD0003, "R9 R7 control load wakes");

    // R6 saturation
    access(1, 2'b01, 0, 32'h0000FFFE, "R9 load near top");
    access(1, 2'b10, 0, 0, "R6 reach top");
    access(0, 2'b01, 0, 0, "R9 full flag");
    access(1, 2'b11, 0, 0, "R6 saturate");
    access(0, 2'b00, 0, 0, "R6 R8 raw read top");
    access(0, 2'b11, 0, 0, "R2 take from top");

    // random mix
    for (int i = 0; i < 600; i++) begin
      bit        wr   = 1'($urandom % 2);
      bit [1:0]  view = 2'($urandom % 4);
      bit [2:0]  id   = 3'($urandom % 8);
      bit [31:0] data = $urandom;
      if (wr && view == 2'b01) data = $urandom % 6;
      access(wr, view, id, data, "R2 R3 R4 R5 R7 R8 R9 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule